// File: doc/BRIEF.md
# Four-Mode Serial Port Controller

This block is a serial port in the classic microcontroller style. Software sees it as two byte-wide registers behind a single select line. One is a control and status register. The other is a data register: writing it queues a transmit word, and reading it returns the last accepted receive word. On the line side there is a receive data pin and a transmit pin. In shift mode the receive pin also works as a driven data line, and the transmit pin carries the shift clock.

Four modes are available. Mode 0 is a synchronous 8-bit shift register clocked at one twelfth of the system clock. Mode 1 is an asynchronous 8-bit frame. Modes 2 and 3 are asynchronous frames that carry a ninth bit. Modes 1 and 3 take their bit rate from an external tick that runs at 16 times the baud rate. Mode 2 divides the system clock by 64, or by 32 when the double-rate input is high. The transmit flag and the receive flag are raised by hardware and are cleared only by software. A multiprocessor enable turns on hardware filtering: in mode 1 it drops frames whose stop bit is bad, and in modes 2 and 3 it drops data frames.

Top module: `serPort`

## Requirements
- R1: After reset the control register reads 0x00, `txdOut` is 1 and `rxdOe` is 0.
- R2: In mode 1, a write of the data register (select 1) sends a frame on `txdOut`: a 0 start bit, then 8 data bits LSB first, then a 1 stop bit. Each bit lasts 16 `baudTick` pulses.
- R3: In modes 2 and 3, the transmit ninth-bit field (control bit 3) is sent as a ninth data bit after the 8 data bits.
- R4: In mode 2 a bit lasts 64 system clocks, or 32 clocks while `dblRate` is 1.
- R5: The transmit flag (control bit 1) is set when the stop bit starts in modes 1 to 3, and after the 8th bit in mode 0. The transmit flag and the receive flag (control bit 0) stay set until software writes the control register.
- R6: In mode 1 with the filter off, a received frame loads the data register, sets the receive flag, and stores the stop bit in the receive ninth-bit field (control bit 2).
- R7: In mode 1 with the filter (control bit 5) on, a frame with a 0 stop bit leaves the receive flag clear and the data register unchanged.
- R8: In modes 2 and 3 the received ninth bit goes to control bit 2. With the filter on, a frame whose ninth bit is 0 is dropped, and a frame whose ninth bit is 1 is accepted.
- R9: While the receive enable (control bit 4) is 0, no frame is received.
- R10: A start bit that has gone high again by mid-bit is discarded. The receiver then accepts the next valid frame.
- R11: In mode 0, a data register write shifts 8 bits LSB first out of `rxdOut` with `rxdOe` high. `txdOut` runs a 12-clock shift clock, low for the first half of each bit and high for the second half.
- R12: In mode 0, reception starts when the receive enable is 1 and the receive flag is 0. `rxdIn` is sampled at the end of each high phase of the shift clock, and the receive flag is set after 8 bits.
- Mode field: control bits 7:6, where 00 is shift, 01 is 8-bit, 10 is fixed-rate 9-bit and 11 is tick-rate 9-bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| regSel | input | 1 | 0 selects the control register, 1 selects the data register |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data of the selected register |
| baudTick | input | 1 | 16x baud pulse for modes 1 and 3 |
| dblRate | input | 1 | Halves the mode 2 bit time |
| rxdIn | input | 1 | Receive data line |
| txdOut | output | 1 | Transmit line, or the shift clock in mode 0 |
| rxdOut | output | 1 | Shift data out in mode 0 |
| rxdOe | output | 1 | Drive enable for rxdOut |

## Verification
The hardest cases to reach from the ports are the rejection paths. A dropped frame leaves no trace of its own. It can only be seen when the data register and the receive flag stay unchanged after a frame that was fully driven. For this reason the bench loads a known word first, and then drives a bad-stop frame, a ninth-bit-zero frame under the filter, a frame with reception disabled, and a glitch shorter than half a bit. After the glitch it sends a valid frame to show that the receiver returned to idle. Mode 0 reception starts by itself once it is enabled, so the bench's line driver tracks the falling edges of the shift clock, with no fixed delay.

// File: rtl/serPortPkg.sv
package serPortPkg;
  typedef enum logic [1:0] {
    MODE_SHIFT  = 2'b00,
    MODE_UART8  = 2'b01,
    MODE_UART9F = 2'b10,
    MODE_UART9V = 2'b11
  } serMode_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic txStart;
    logic ovTick;
    logic rxEn;
    logic shiftRxArm;
  } serStrobe_t;

  // Events from datapath back to control
  typedef struct packed {
    logic       txDone;
    logic       rxDone;
    logic [7:0] rxWord;
    logic       rxBit9;
    logic       rxStopOk;
  } serEvent_t;
endpackage

// File: rtl/serPortTicks.sv
module serPortTicks
  import serPortPkg::*;
#(
  parameter int SLOW_DIV = 4,
  parameter int FAST_DIV = 2
) (
  input  logic     clk,
  input  logic     rstN,
  input  serMode_t mode,
  input  logic     baudTick,
  input  logic     dblRate,
  output logic     ovTick
);
  localparam int CW = $clog2(SLOW_DIV + 1);

  logic [CW-1:0] divCnt;
  logic [CW-1:0] divLast;

  assign divLast = dblRate ? CW'(FAST_DIV - 1) : CW'(SLOW_DIV - 1);

  always_ff @(posedge clk) begin
    if (!rstN) divCnt <= '0;
    else if (mode != MODE_UART9F || divCnt >= divLast) divCnt <= '0;
    else divCnt <= divCnt + 1'b1;
  end

  always_comb begin
    if (mode == MODE_UART9F) ovTick = (divCnt == divLast);
    else ovTick = (mode != MODE_SHIFT) && baudTick;
  end

  // R4: the fixed-rate divider never produces back-to-back ticks
  a_r4_tick_spacing: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_UART9F && ovTick) |=> (mode != MODE_UART9F || !ovTick));
endmodule

// File: rtl/serPortCtrl.sv
module serPortCtrl
  import serPortPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic       regSel,
  input  logic [7:0] wrData,
  output logic [7:0] rdData,
  input  logic       ovTickIn,
  input  serEvent_t  ev,
  output serStrobe_t st,
  output serMode_t   mode,
  output logic [8:0] txWord
);
  logic sm2, ren, tb8, rb8, ti, ri;
  logic [7:0] rxBuf;
  logic accept;
  logic ctlWr;

  assign ctlWr = wrEn && !regSel;

  always_comb begin
    case (mode)
      MODE_SHIFT: accept = 1'b1;
      MODE_UART8: accept = !sm2 || ev.rxStopOk;
      default:    accept = !sm2 || ev.rxBit9;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mode  <= MODE_SHIFT;
      {sm2, ren, tb8, rb8, ti, ri} <= '0;
      rxBuf <= '0;
    end else begin
      if (ctlWr) begin
        mode <= serMode_t'(wrData[7:6]);
        {sm2, ren, tb8, rb8, ti, ri} <= wrData[5:0];
      end
      // hardware sets win over a simultaneous software write
      if (ev.txDone) ti <= 1'b1;
      if (ev.rxDone && accept) begin
        ri    <= 1'b1;
        rxBuf <= ev.rxWord;
        if (mode != MODE_SHIFT) rb8 <= ev.rxBit9;
      end
    end
  end

  assign rdData        = regSel ? rxBuf : {mode, sm2, ren, tb8, rb8, ti, ri};
  assign st.txStart    = wrEn && regSel;
  assign st.ovTick     = ovTickIn;
  assign st.rxEn       = ren;
  assign st.shiftRxArm = ren && !ri;
  assign txWord        = {tb8, wrData};

  // R5: flags are only cleared by a control write
  a_r5_ti_hold: assert property (@(posedge clk) disable iff (!rstN)
    (ti && !ctlWr) |=> ti);
  a_r5_ri_hold: assert property (@(posedge clk) disable iff (!rstN)
    (ri && !ctlWr) |=> ri);
  // R8: filtered data frame leaves buffer and flag alone
  a_r8_filter: assert property (@(posedge clk) disable iff (!rstN)
    (ev.rxDone && mode[1] && sm2 && !ev.rxBit9 && !ctlWr)
      |=> ($stable(rxBuf) && ri == $past(ri)));
endmodule

// File: rtl/serPortDatapath.sv
module serPortDatapath
  import serPortPkg::*;
#(
  parameter int OVS       = 16,
  parameter int SHIFT_DIV = 12
) (
  input  logic       clk,
  input  logic       rstN,
  input  serMode_t   mode,
  input  serStrobe_t st,
  input  logic [8:0] txWord,
  input  logic       rxdIn,
  output logic       txdOut,
  output logic       rxdOut,
  output logic       rxdOe,
  output serEvent_t  ev
);
  localparam int OW         = $clog2(OVS);
  localparam int SW         = $clog2(SHIFT_DIV);
  localparam int HALF_OVS   = OVS / 2;
  localparam int SHIFT_HALF = SHIFT_DIV / 2;

  typedef enum logic [1:0] {R_IDLE, R_START, R_BITS} rxState_t;

  logic [3:0] lastIdx;
  assign lastIdx = (mode == MODE_UART8) ? 4'd9 : 4'd10;

  // ---------------- mode 0 shift engine ----------------
  logic          m0Busy, m0Rx;
  logic [SW-1:0] m0Phase;
  logic [2:0]    m0Cnt;
  logic [7:0]    m0Sh;
  logic          m0Wrap, m0Last;

  assign m0Wrap = (m0Phase == SW'(SHIFT_DIV - 1));
  assign m0Last = m0Busy && m0Wrap && (m0Cnt == 3'd7);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      m0Busy <= 1'b0; m0Rx <= 1'b0; m0Phase <= '0; m0Cnt <= '0; m0Sh <= '0;
    end else if (!m0Busy) begin
      if (mode == MODE_SHIFT && st.txStart) begin
        m0Busy <= 1'b1; m0Rx <= 1'b0; m0Phase <= '0; m0Cnt <= '0;
        m0Sh   <= txWord[7:0];
      end else if (mode == MODE_SHIFT && st.shiftRxArm) begin
        m0Busy <= 1'b1; m0Rx <= 1'b1; m0Phase <= '0; m0Cnt <= '0;
      end
    end else if (m0Wrap) begin
      m0Phase <= '0;
      m0Cnt   <= m0Cnt + 1'b1;
      m0Sh    <= {m0Rx ? rxdIn : 1'b1, m0Sh[7:1]};
      if (m0Cnt == 3'd7) m0Busy <= 1'b0;
    end else begin
      m0Phase <= m0Phase + 1'b1;
    end
  end

  // ---------------- asynchronous transmitter ----------------
  logic          txBusy;
  logic [10:0]   txSh;
  logic [3:0]    txCnt;
  logic [OW-1:0] txTick;
  logic          txBitEnd, asyncTxDone;

  assign txBitEnd    = txBusy && st.ovTick && (txTick == OW'(OVS - 1));
  assign asyncTxDone = txBitEnd && (txCnt + 4'd1 == lastIdx);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txBusy <= 1'b0; txSh <= '1; txCnt <= '0; txTick <= '0;
    end else if (!txBusy) begin
      if (mode != MODE_SHIFT && st.txStart) begin
        txBusy <= 1'b1;
        txSh   <= (mode == MODE_UART8) ? {2'b11, txWord[7:0], 1'b0}
                                       : {1'b1, txWord[8], txWord[7:0], 1'b0};
        txCnt  <= '0;
        txTick <= '0;
      end
    end else if (st.ovTick) begin
      if (txTick == OW'(OVS - 1)) begin
        txTick <= '0;
        txSh   <= {1'b1, txSh[10:1]};
        txCnt  <= txCnt + 1'b1;
        if (txCnt == lastIdx) txBusy <= 1'b0;
      end else begin
        txTick <= txTick + 1'b1;
      end
    end
  end

  // ---------------- asynchronous receiver ----------------
  logic          rxMeta, rxSync, rxPrev;
  rxState_t      rxState;
  logic [OW-1:0] rxTick;
  logic [3:0]    rxCnt;
  logic [9:0]    rxSh;
  logic          asyncRxDone;

  always_ff @(posedge clk) begin
    if (!rstN) {rxMeta, rxSync, rxPrev} <= 3'b111;
    else {rxMeta, rxSync, rxPrev} <= {rxdIn, rxMeta, rxSync};
  end

  assign asyncRxDone = (rxState == R_BITS) && st.ovTick &&
                       (rxTick == OW'(OVS - 1)) && (rxCnt == lastIdx - 4'd1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxState <= R_IDLE; rxTick <= '0; rxCnt <= '0; rxSh <= '0;
    end else begin
      case (rxState)
        R_IDLE: if (mode != MODE_SHIFT && st.rxEn && rxPrev && !rxSync) begin
          rxState <= R_START;
          rxTick  <= '0;
        end
        R_START: if (st.ovTick) begin
          if (rxTick == OW'(HALF_OVS - 1)) begin
            rxTick <= '0;
            rxCnt  <= '0;
            rxState <= rxSync ? R_IDLE : R_BITS;
          end else begin
            rxTick <= rxTick + 1'b1;
          end
        end
        R_BITS: if (st.ovTick) begin
          if (rxTick == OW'(OVS - 1)) begin
            rxTick <= '0;
            if (rxCnt == lastIdx - 4'd1) rxState <= R_IDLE;
            else begin
              rxSh  <= {rxSync, rxSh[9:1]};
              rxCnt <= rxCnt + 1'b1;
            end
          end else begin
            rxTick <= rxTick + 1'b1;
          end
        end
        default: rxState <= R_IDLE;
      endcase
    end
  end

  // ---------------- outputs and events ----------------
  always_comb begin
    if (mode == MODE_SHIFT) txdOut = m0Busy ? (m0Phase >= SW'(SHIFT_HALF)) : 1'b1;
    else txdOut = txBusy ? txSh[0] : 1'b1;
  end

  assign rxdOut      = m0Sh[0];
  assign rxdOe       = m0Busy && !m0Rx;
  assign ev.txDone   = (m0Last && !m0Rx) || asyncTxDone;
  assign ev.rxDone   = (m0Last && m0Rx) || asyncRxDone;
  assign ev.rxWord   = (m0Busy && m0Rx) ? {rxdIn, m0Sh[7:1]}
                     : (mode == MODE_UART8) ? rxSh[9:2] : rxSh[8:1];
  assign ev.rxBit9   = (mode == MODE_UART8) ? rxSync : rxSh[9];
  assign ev.rxStopOk = rxSync;

  // R9: a disabled receiver never leaves idle
  a_r9_stay_idle: assert property (@(posedge clk) disable iff (!rstN)
    (rxState == R_IDLE && !st.rxEn) |=> rxState == R_IDLE);
  // R5: the transmit flag event coincides with the stop bit reaching the line
  a_r5_stop_after_flag: assert property (@(posedge clk) disable iff (!rstN)
    asyncTxDone |=> txdOut);
  // R11: a shift operation begins with the clock low
  a_r11_clock_low_first: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(m0Busy) && mode == MODE_SHIFT) |-> !txdOut);
endmodule

// File: rtl/serPort.sv
module serPort
  import serPortPkg::*;
#(
  parameter int OVS       = 16,
  parameter int SHIFT_DIV = 12,
  parameter int SLOW_DIV  = 4,
  parameter int FAST_DIV  = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic       regSel,
  input  logic [7:0] wrData,
  output logic [7:0] rdData,
  input  logic       baudTick,
  input  logic       dblRate,
  input  logic       rxdIn,
  output logic       txdOut,
  output logic       rxdOut,
  output logic       rxdOe
);
  serMode_t   mode;
  serStrobe_t st;
  serEvent_t  ev;
  logic       ovTick;
  logic [8:0] txWord;

  serPortTicks #(.SLOW_DIV(SLOW_DIV), .FAST_DIV(FAST_DIV)) i_ticks (
    .clk(clk), .rstN(rstN), .mode(mode), .baudTick(baudTick),
    .dblRate(dblRate), .ovTick(ovTick)
  );

  serPortCtrl i_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .regSel(regSel), .wrData(wrData),
    .rdData(rdData), .ovTickIn(ovTick), .ev(ev), .st(st), .mode(mode),
    .txWord(txWord)
  );

  serPortDatapath #(.OVS(OVS), .SHIFT_DIV(SHIFT_DIV)) i_data (
    .clk(clk), .rstN(rstN), .mode(mode), .st(st), .txWord(txWord),
    .rxdIn(rxdIn), .txdOut(txdOut), .rxdOut(rxdOut), .rxdOe(rxdOe), .ev(ev)
  );
endmodule

// File: tb/test_serPort.sv
module test_serPort;
  logic clk = 1'b0, rstN = 1'b0;
  logic wrEn = 1'b0, regSel = 1'b0, baudTick = 1'b0, dblRate = 1'b0, rxdIn = 1'b1;
  logic [7:0] wrData = '0, rdData;
  logic txdOut, rxdOut, rxdOe;

  int checks = 0, errors = 0, cyc = 0, bitClk = 64, tickCnt = 0;
  bit txMonOn = 1'b0, finished = 1'b0;
  logic [8:0] qW[$];
  int         qN[$];
  string      qR[$];

  serPort i_serPort (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .regSel(regSel), .wrData(wrData),
    .rdData(rdData), .baudTick(baudTick), .dblRate(dblRate), .rxdIn(rxdIn),
    .txdOut(txdOut), .rxdOut(rxdOut), .rxdOe(rxdOe)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) begin   // 16x tick every 4 clocks -> 64-clock bits
    baudTick <= (tickCnt == 3);
    tickCnt  <= (tickCnt == 3) ? 0 : tickCnt + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic regWr(input bit a, input logic [7:0] d);
    @(negedge clk); wrEn = 1'b1; regSel = a; wrData = d;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic regRd(input bit a, output logic [7:0] v);
    @(negedge clk); regSel = a; #1 v = rdData;
  endtask

  // scoreboard push + timing of the transmit flag
  task automatic sendTx(input logic [8:0] w, input int n, input string req, input int stopIdx);
    logic [7:0] v;
    int t0;
    qW.push_back(w); qN.push_back(n); qR.push_back(req);
    regWr(1'b1, w[7:0]);
    t0 = cyc;
    do regRd(1'b0, v); while (!v[1] && cyc - t0 < 2000);
    chk((cyc - t0) >= stopIdx * bitClk - 8 && (cyc - t0) <= stopIdx * bitClk + 8,
        "R5/R4 flag timing", cyc - t0, stopIdx * bitClk);
    repeat (3 * bitClk) @(negedge clk);
  endtask

  // tx monitor: decodes the line and compares against the queue
  always begin
    @(negedge clk);
    if (txMonOn && txdOut === 1'b0) begin
      logic [8:0] got, exp;
      int n; string req; bit ok;
      got = '0;
      if (qW.size() == 0) begin exp = '1; n = 8; req = "R2 unexpected"; end
      else begin exp = qW.pop_front(); n = qN.pop_front(); req = qR.pop_front(); end
      repeat (bitClk / 2) @(negedge clk);
      ok = (txdOut == 1'b0);
      for (int i = 0; i < n; i++) begin
        repeat (bitClk) @(negedge clk);
        got[i] = txdOut;
      end
      repeat (bitClk) @(negedge clk);
      ok = ok && txdOut;
      if (n == 8) exp[8] = 1'b0;
      chk(ok && got == exp, req, {ok, got}, {1'b1, exp});
    end
  end

  task automatic sendRx(input logic [8:0] w, input int n, input bit stopBit);
    rxdIn = 1'b0; repeat (bitClk) @(negedge clk);
    for (int i = 0; i < n; i++) begin rxdIn = w[i]; repeat (bitClk) @(negedge clk); end
    rxdIn = stopBit; repeat (bitClk) @(negedge clk);
    rxdIn = 1'b1; repeat (2 * bitClk) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v, b;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    regRd(1'b0, v);
    chk(v == 8'h00, "R1 ctrl", v, 0);
    chk(txdOut == 1'b1, "R1 txd", txdOut, 1);
    chk(rxdOe == 1'b0, "R1 oe", rxdOe, 0);

    // ---- asynchronous transmit ----
    txMonOn = 1'b1;
    regWr(1'b0, 8'h50);                       // mode 1, rx enabled
    sendTx(9'h0A5, 8, "R2 frame", 9);
    regRd(1'b0, v);
    chk(v[1] == 1'b1, "R5 flag held", v[1], 1);
    regWr(1'b0, 8'h50);
    regRd(1'b0, v);
    chk(v[1] == 1'b0, "R5 flag cleared", v[1], 0);

    regWr(1'b0, 8'h88);                       // mode 2, tb8=1, slow
    sendTx(9'h15A, 9, "R3 ninth bit", 10);
    dblRate = 1'b1; bitClk = 32;
    regWr(1'b0, 8'h80);                       // mode 2, tb8=0, double rate
    sendTx(9'h00F, 9, "R4 double rate", 10);
    chk(qW.size() == 0, "R2 all frames seen", qW.size(), 0);
    txMonOn = 1'b0; dblRate = 1'b0; bitClk = 64;

    // ---- asynchronous receive ----
    regWr(1'b0, 8'h50);
    sendRx(9'h03C, 8, 1'b1);
    regRd(1'b1, b); regRd(1'b0, v);
    chk(b == 8'h3C, "R6 data", b, 8'h3C);
    chk(v[0] == 1'b1, "R6 flag", v[0], 1);
    chk(v[2] == 1'b1, "R6 stop in bit 2", v[2], 1);

    regWr(1'b0, 8'h70);                       // filter on
    sendRx(9'h081, 8, 1'b0);
    regRd(1'b1, b); regRd(1'b0, v);
    chk(b == 8'h3C && v[0] == 1'b0, "R7 bad stop dropped", {v[0], b}, 8'h3C);

    regWr(1'b0, 8'hD0);                       // mode 3
    sendRx(9'h077, 9, 1'b1);
    regRd(1'b1, b); regRd(1'b0, v);
    chk(b == 8'h77 && v[0] && !v[2], "R8 ninth=0 stored", {v[2], v[0], b}, {2'b01, 8'h77});
    regWr(1'b0, 8'hF0);                       // mode 3 + filter
    sendRx(9'h011, 9, 1'b1);
    regRd(1'b1, b); regRd(1'b0, v);
    chk(b == 8'h77 && !v[0], "R8 data frame dropped", {v[0], b}, 8'h77);
    sendRx(9'h122, 9, 1'b1);
    regRd(1'b1, b); regRd(1'b0, v);
    chk(b == 8'h22 && v[0] && v[2], "R8 address frame kept", {v[2], v[0], b}, {2'b11, 8'h22});

    regWr(1'b0, 8'h40);                       // mode 1, rx disabled
    sendRx(9'h099, 8, 1'b1);
    regRd(1'b1, b); regRd(1'b0, v);
    chk(b == 8'h22 && !v[0], "R9 disabled", {v[0], b}, 8'h22);

    regWr(1'b0, 8'h50);
    rxdIn = 1'b0; repeat (16) @(negedge clk); rxdIn = 1'b1;
    repeat (12 * bitClk) @(negedge clk);
    regRd(1'b1, b); regRd(1'b0, v);
    chk(b == 8'h22 && !v[0], "R10 glitch rejected", {v[0], b}, 8'h22);
    sendRx(9'h042, 8, 1'b1);
    regRd(1'b1, b);
    chk(b == 8'h42, "R10 recovered", b, 8'h42);

    // ---- mode 0 transmit ----
    regWr(1'b0, 8'h00);
    begin
      logic p; logic [7:0] got; int lastRise; bit perOk, oeOk;
      perOk = 1'b1; oeOk = 1'b1; got = '0; lastRise = 0;
      regWr(1'b1, 8'hC6);
      p = txdOut;
      for (int i = 0; i < 8; i++) begin
        do begin @(negedge clk); if (!(!p && txdOut)) p = txdOut; else break; end while (1);
        p = txdOut;
        got[i] = rxdOut;
        oeOk = oeOk && rxdOe;
        if (i > 0 && cyc - lastRise != 12) perOk = 1'b0;
        lastRise = cyc;
      end
      chk(got == 8'hC6 && oeOk, "R11 shifted bits", got, 8'hC6);
      chk(perOk, "R11 clock period", perOk, 1);
      repeat (20) @(negedge clk);
      regRd(1'b0, v);
      chk(v[1] == 1'b1, "R5 mode0 flag", v[1], 1);
      chk(rxdOe == 1'b0, "R11 oe released", rxdOe, 0);
    end

    // ---- mode 0 receive ----
    begin
      logic [7:0] pat; pat = 8'hB3;
      fork
        begin
          logic p; p = 1'b1;
          for (int i = 0; i < 8; i++) begin
            do begin @(negedge clk); if (!(p && !txdOut)) p = txdOut; else break; end while (1);
            p = txdOut;
            rxdIn = pat[i];
          end
        end
        regWr(1'b0, 8'h10);
      join
      begin
        int t0; t0 = cyc;
        do regRd(1'b0, v); while (!v[0] && cyc - t0 < 500);
      end
      regRd(1'b1, b);
      chk(v[0] && b == 8'hB3, "R12 shift receive", {v[0], b}, {1'b1, 8'hB3});
      regWr(1'b0, 8'h00);
      rxdIn = 1'b1;
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule